// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side command interpreter of a byte-wide parallel NOR flash model. A host issues single-cycle write strobes, each carrying an address and a data byte, and single-cycle read strobes. Contents can only change after a multi-write unlock sequence. After the unlock, the block can program one byte, erase one 4 KB sector, erase the whole array, or switch reads over to an identification view that returns vendor and device codes.

Once a program or erase is accepted, the block stays busy for a parameterized number of clock cycles and ignores every write. It has no ready pin. Instead, busy status appears on the read data: bit 7 is a data-polling flag and bit 6 flips on every read. The backing store is a small synthesizable array. Each sector is represented by a window of `2^OFS_W` bytes, so sector-level erase behaves as in a full-size part without the storage cost.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rdata` is 00h, the block is in normal read mode and every byte reads FFh. A read strobe updates `rdata` at the next clock edge, and `rdata` holds that value until the next read strobe.
- R2: Command cycles compare only address bits 14..0, so bit 15 has no effect. The first unlock write is AAh at 5555h and the second is 55h at 2AAAh.
- R3: A third write of 90h at 5555h enters identification mode. In that mode, a read with address bit 0 clear returns BFh and a read with address bit 0 set returns parameter `DEV_CODE` (default B7h).
- R4: Identification mode is left by either of two writes:
  - a single write of F0h at any address;
  - the sequence AAh@5555h, 55h@2AAAh, F0h@5555h.

  Any other write leaves the block in identification mode. After exit, reads return array data.
- R5: A third write of A0h at 5555h arms a byte program, and the next write supplies the target address and data. The stored byte becomes old AND new. While busy, read bit 7 is the complement of bit 7 of the written data.
- R6: Sector erase is the sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. Address bits 15..12 of that last write select the sector, and every byte of that sector becomes FFh. Other sectors are unchanged. While busy, read bit 7 is 0.
- R7: The same prefix ending with 10h at 5555h erases the whole array to FFh. A sixth write of 10h at any other address, or any other sixth write, aborts the sequence.
- R8: While busy, read bit 6 is 1 on the first busy read and inverts on every later busy read, and bits 5..0 read 0. Take the strobe that starts an operation as clock edge k. Reads taken at edges k+1 through k+N report busy, where N is `PROG_CYC` for a program and `ERASE_CYC` for an erase. Reads from edge k+N+1 on return array data.
- R9: A write that does not match the expected step of a sequence returns the block to read mode. A later write that would have completed that sequence changes nothing.
- R10: While busy, every write is ignored, including F0h and full command sequences. The array afterwards holds only the result of the running operation.
- R11: Array byte index is {address bits 15..12, address bits OFS_W-1..0}. Address bits 11..OFS_W are ignored, so addresses that differ only there alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, registered |

## Verification
A sequencer stuck in the wrong step shows at the ports on the very next read. Examples include an unlock step that survives a bad write, or identification mode that was never entered or never left. Such a read returns identification codes instead of array data, or the reverse, or a later program lands where the sequence should have been dead. A wrong busy counter or operation latch shows within one operation length. The polling bits then report busy too long or too short by a countable number of reads, bit 7 carries the wrong polarity, or the wrong sector comes back FFh. A toggle register that fails to restart or flip breaks the bit 6 alternation on the first two busy reads.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SECT_LSB  = 12,
  parameter int unsigned OFS_W     = 4,
  parameter logic [7:0]  DEV_CODE  = 8'hB7,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int unsigned SEC_W = ADDR_W - SECT_LSB;
  localparam int unsigned IDX_W = SEC_W + OFS_W;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  localparam logic [3:0] ST_READ = 4'd0, ST_U1 = 4'd1, ST_U2 = 4'd2, ST_PGM = 4'd3,
                         ST_E3 = 4'd4, ST_E4 = 4'd5, ST_E5 = 4'd6, ST_ID = 4'd7,
                         ST_IDU1 = 4'd8, ST_IDU2 = 4'd9, ST_BUSY = 4'd10;
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2;

  logic [3:0]       state;
  logic [1:0]       op;
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [7:0]       tgt_data;
  logic [IDX_W-1:0] tgt_idx;
  logic [7:0]       mem [DEPTH];

  wire [14:0]      cmd_a   = addr[14:0];
  wire             busy    = (state == ST_BUSY);
  wire             in_id   = (state == ST_ID) || (state == ST_IDU1) || (state == ST_IDU2);
  wire             at_5555 = (cmd_a == 15'h5555);
  wire             hit_aa  = at_5555 && (wdata == 8'hAA);
  wire             hit_55  = (cmd_a == 15'h2AAA) && (wdata == 8'h55);
  wire [IDX_W-1:0] a_idx   = {addr[ADDR_W-1:SECT_LSB], addr[OFS_W-1:0]};
  wire             dq7     = (op == OP_PROG) ? ~tgt_data[7] : 1'b0;

  logic [7:0] rd_val;
  always_comb begin
    if (busy)       rd_val = {dq7, tog, 6'b0};
    else if (in_id) rd_val = addr[0] ? DEV_CODE : 8'hBF;
    else            rd_val = mem[a_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_READ;
      op       <= OP_PROG;
      cnt      <= '0;
      tog      <= 1'b1;
      tgt_data <= '0;
      tgt_idx  <= '0;
      rdata    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (rd_en) begin
        rdata <= rd_val;
        if (busy) tog <= ~tog;
      end
      if (busy) begin
        if (cnt == CNT_W'(1)) begin
          state <= ST_READ;
          if (op == OP_PROG) begin
            mem[tgt_idx] <= mem[tgt_idx] & tgt_data;
          end else begin
            for (int i = 0; i < DEPTH; i++)
              if (op == OP_CHIP || IDX_W'(i) >> OFS_W == tgt_idx >> OFS_W)
                mem[i] <= 8'hFF;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (wr_en) begin
        case (state)
          ST_READ: state <= hit_aa ? ST_U1 : ST_READ;
          ST_U1:   state <= hit_55 ? ST_U2 : ST_READ;
          ST_U2: begin
            if (at_5555 && wdata == 8'h90)      state <= ST_ID;
            else if (at_5555 && wdata == 8'hA0) state <= ST_PGM;
            else if (at_5555 && wdata == 8'h80) state <= ST_E3;
            else                                state <= ST_READ;
          end
          ST_PGM: begin
            state    <= ST_BUSY;
            op       <= OP_PROG;
            cnt      <= CNT_W'(PROG_CYC);
            tog      <= 1'b1;
            tgt_data <= wdata;
            tgt_idx  <= a_idx;
          end
          ST_E3: state <= hit_aa ? ST_E4 : ST_READ;
          ST_E4: state <= hit_55 ? ST_E5 : ST_READ;
          ST_E5: begin
            if (wdata == 8'h30 || (wdata == 8'h10 && at_5555)) begin
              state   <= ST_BUSY;
              op      <= (wdata == 8'h30) ? OP_SECT : OP_CHIP;
              cnt     <= CNT_W'(ERASE_CYC);
              tog     <= 1'b1;
              tgt_idx <= a_idx;
            end else begin
              state <= ST_READ;
            end
          end
          ST_ID:   state <= (wdata == 8'hF0) ? ST_READ : (hit_aa ? ST_IDU1 : ST_ID);
          ST_IDU1: state <= (wdata == 8'hF0) ? ST_READ : (hit_55 ? ST_IDU2 : ST_ID);
          ST_IDU2: state <= (wdata == 8'hF0) ? ST_READ : ST_ID;
          default: state <= ST_READ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [3:0]        state,
  input logic [1:0]        op,
  input logic [7:0]        tgt_data
);
  localparam logic [3:0] C_READ = 4'd0, C_U1 = 4'd1, C_ID = 4'd7, C_IDU1 = 4'd8,
                         C_IDU2 = 4'd9, C_BUSY = 4'd10;

  wire c_busy = (state == C_BUSY);
  wire c_id   = (state == C_ID) || (state == C_IDU1) || (state == C_IDU2);

  assert_toggle_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && rd_en) ##1 (c_busy && rd_en) |=> rdata[6] != $past(rdata[6]));

  assert_poll_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && rd_en) |=> rdata[5:0] == 6'b0);

  assert_prog_dq7_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && rd_en && op == 2'd0) |=> rdata[7] == ~$past(tgt_data[7]));

  assert_erase_dq7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && rd_en && op != 2'd0) |=> rdata[7] == 1'b0);

  assert_id_mfr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_id && rd_en && !addr[0]) |=> rdata == 8'hBF);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_U1 && wr_en && !(addr[14:0] == 15'h2AAA && wdata == 8'h55)) |=> state == C_READ);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && wr_en) |=> (state == C_BUSY || state == C_READ));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int PROG_N  = 8;
  localparam int ERASE_N = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected read result %02h (no expectation queued)", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic burst(input logic [15:0] a, input int n, input int busy_n,
                       input logic b7, input logic [7:0] fin, input string t);
    rd_en = 1'b1; addr = a;
    for (int j = 1; j <= n; j++) begin
      if (j <= busy_n) exp_q.push_back({b7, (j % 2 == 1), 6'b0});
      else             exp_q.push_back(fin);
      tag_q.push_back($sformatf("%s read %0d", t, j));
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] code);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== 8'h00) begin fails++; $display("FAIL R1 reset rdata: got %02h expected 00", rdata); end
    rst_n = 1'b1;
    rd(16'h0000, 8'hFF, "R1 erased after reset");
    rd(16'h7FFF, 8'hFF, "R1 erased after reset top");

    // R2: bit 15 set on unlock addresses; R5 program with polling; R8 timing
    wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'hA0);
    wr(16'h0123, 8'h5A);
    burst(16'h0123, PROG_N + 2, PROG_N, 1'b1, 8'h5A, "R2/R5/R8 program 5A");
    rd(16'h0753, 8'h5A, "R11 alias of offset bits");

    // R5: AND with old data; dq7 = ~1 = 0
    unlock(8'hA0); wr(16'h0123, 8'hF0);
    burst(16'h0123, PROG_N + 1, PROG_N, 1'b0, 8'h50, "R5 program AND");

    // R10: writes during busy ignored
    unlock(8'hA0); wr(16'h0200, 8'h0F);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0200, 8'h00);
    wr(16'h0000, 8'hF0);
    rd(16'h0200, 8'h0F, "R10 busy writes ignored");
    rd(16'h0200, 8'h0F, "R10 no later program");

    // R3/R4 identification mode
    unlock(8'h90);
    rd(16'h0000, 8'hBF, "R3 manufacturer code");
    rd(16'h0001, 8'hB7, "R3 device code");
    wr(16'h1234, 8'h33);
    rd(16'h0000, 8'hBF, "R4 other write keeps ID");
    wr(16'h1234, 8'hF0);
    rd(16'h0000, 8'h0F, "R4 single F0 exit");
    unlock(8'h90);
    rd(16'h0001, 8'hB7, "R3 re-entry");
    unlock(8'hF0);
    rd(16'h0001, 8'hFF, "R4 three-cycle exit");

    // R9 abort
    wr(16'h5555, 8'hAA); wr(16'h1AAA, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0200, 8'h00);
    rd(16'h0200, 8'h0F, "R9 bad address aborts");
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h54); wr(16'h0200, 8'h00);
    rd(16'h0200, 8'h0F, "R9 bad data aborts");

    // R6 sector erase
    unlock(8'hA0); wr(16'h1005, 8'h33);
    repeat (PROG_N + 1) @(negedge clk);
    rd(16'h1005, 8'h33, "R5 program sector 1");
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0ABC, 8'h30);
    burst(16'h0200, ERASE_N + 2, ERASE_N, 1'b0, 8'hFF, "R6/R8 sector erase");
    rd(16'h0123, 8'hFF, "R6 sector 0 erased");
    rd(16'h1005, 8'h33, "R6 sector 1 kept");

    // R7 chip erase: wrong address aborts, then real
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h1555, 8'h10);
    rd(16'h1005, 8'h33, "R7 10h off 5555h aborts");
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h20);
    rd(16'h1005, 8'h33, "R7 bad sixth code aborts");
    unlock(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h10);
    burst(16'h1005, ERASE_N + 1, ERASE_N, 1'b0, 8'hFF, "R7 chip erase");
    rd(16'h1005, 8'hFF, "R7 all erased");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL %0d queued reads never produced, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule